// File: doc/BRIEF.md
# Serial Register Host Interface

This block is a serial slave that gives a host processor access to a bank of 8-bit control and status registers over four wires: a chip select (active low), a serial clock, a serial data input and a serial data output with its own output enable. The serial pins are brought into the system clock domain through synchronizers, and every serial edge is detected there. A frame of exactly sixteen serial clocks carries a command byte followed by a data byte. A read returns the selected register on the data output during the data byte. A write updates the register once the last data bit has arrived.

The register space is addressed with five bits. In the normal (primary) bank, addresses 00h to 15h hold a read-only identification value, three read-only status registers that mirror the `stat_in` input, a write-only reset register and general configuration registers. A pointer register at 1Fh selects the bank. When it holds the key value, addresses 00h to 0Fh reach a second bank of sixteen expanded registers. The pointer register stays reachable from either bank. All configuration contents are presented in parallel on `cfg_prim` and `cfg_exp`, and `exp_mode` shows the selected bank.

Top module: `sri_top`

## Requirements
- R1: A frame is 16 rising edges of `sclk` while `cs_n` is low, sent least significant bit first. Bit 0 is the direction (1 = read, 0 = write), bits 1 to 5 are the register address A[4:0], bits 6 and 7 are ignored, and bits 8 to 15 are data bits D0 to D7.
- R2: On a read, bit D0 is driven on `sdo` after the falling edge that follows the 8th rising edge, and D1 to D7 follow on the next falling edges. `sdo_oe` is high from that first falling edge until `cs_n` goes high.
- R3: `sdo_oe` is low whenever `cs_n` is high, and it stays low for the whole of a write frame.
- R4: A frame in which `cs_n` goes high before the 16th rising edge changes no register.
- R5: In the primary bank, the configuration registers at 01-03, 06-09, 0B-12, 14 and 15 hex reset to 00h, can be written and read back, and appear as byte i of `cfg_prim` (bits 8*i+7 down to 8*i). Read-only slots and the reset slot show 00h on `cfg_prim`. Addresses 16h to 1Eh read 00h and ignore writes.
- R6: Address 00h in the primary bank reads the ID_VALUE parameter (default A7h), and writes to it are ignored.
- R7: Primary addresses 04h, 05h and 13h read bytes 0, 1 and 2 of `stat_in` as they stand when the command byte completes, and writes to them are ignored.
- R8: A write of any value to primary address 0Ah returns every register, the bank pointer included, to 00h on the following clock. Address 0Ah reads 00h.
- R9: The pointer register at 1Fh resets to 00h and can be read and written from either bank. While it holds EXP_KEY (default 01h), `exp_mode` is high and addresses 00h to 0Fh reach expanded register n, which appears as byte n of `cfg_exp`. With any other value the primary bank is decoded, and primary contents are kept while the expanded bank is selected.
- R10: While the expanded bank is selected, addresses 10h to 1Eh read 00h and writes to them change no register.
- R11: The values of command bits 6 and 7 have no effect on which register is accessed.
- R12: After reset, `sdo_oe` and `exp_mode` are low and `cfg_prim` and `cfg_exp` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select that frames a transfer |
| sdi | input | 1 | Serial command and write data |
| stat_in | input | 24 | Status bytes shown at primary addresses 04h, 05h and 13h (byte 0, 1, 2) |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for `sdo` (high drives the line) |
| exp_mode | output | 1 | High while the expanded bank is selected |
| cfg_prim | output | 176 | Primary register contents, byte i = address i, for i from 0 to 21 |
| cfg_exp | output | 128 | Expanded register contents, byte n = expanded address n |

## Verification
On every cycle, the bound checker confirms that the bit counter never passes sixteen, that a write strobe occurs only once a frame is complete, that the output enable is low for write commands and once chip select has been high past the synchronizer depth, that the data output moves only after a detected falling serial edge, and that a reset-register write leaves all contents at zero one clock later. The address decode across both banks, the read-only and write-only slots, the ignored command bits, the discarded short frames and the preservation of primary contents across bank switches can be shown only by the bench's scenarios. These scenarios compare read-back bytes and the parallel register outputs against a model of the register map.

// File: rtl/sri_pkg.sv
package sri_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 8;
  localparam int CMD_BITS   = 8;
  localparam int FRAME_BITS = CMD_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int PRIM_CNT   = 22;
  localparam int EXP_CNT    = 16;
  localparam int EXP_AW     = $clog2(EXP_CNT);
  localparam int STAT_CNT   = 3;

  localparam logic [ADDR_W-1:0] ADR_ID   = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_ST0  = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_ST1  = 5'h05;
  localparam logic [ADDR_W-1:0] ADR_RST  = 5'h0A;
  localparam logic [ADDR_W-1:0] ADR_ST2  = 5'h13;
  localparam logic [ADDR_W-1:0] ADR_PTR  = 5'h1F;
  localparam logic [ADDR_W-1:0] PRIM_TOP = ADDR_W'(PRIM_CNT - 1);

  // True for primary slots that hold writable configuration storage.
  function automatic logic prim_is_rw(input logic [ADDR_W-1:0] a);
    return (a <= PRIM_TOP) && (a != ADR_ID) && (a != ADR_RST) &&
           (a != ADR_ST0) && (a != ADR_ST1) && (a != ADR_ST2);
  endfunction
endpackage

// File: rtl/sri_sync.sv
module sri_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic sdi_s
);
  logic [STAGES-1:0] sc_q, cs_q, sd_q;
  logic              sc_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q      <= '0;
      cs_q      <= '1;
      sd_q      <= '0;
      sc_prev_q <= 1'b0;
    end else begin
      sc_q      <= {sc_q[STAGES-2:0], sclk};
      cs_q      <= {cs_q[STAGES-2:0], cs_n};
      sd_q      <= {sd_q[STAGES-2:0], sdi};
      sc_prev_q <= sc_q[STAGES-1];
    end
  end

  assign sclk_rise = sc_q[STAGES-1] & ~sc_prev_q;
  assign sclk_fall = ~sc_q[STAGES-1] & sc_prev_q;
  assign cs_act    = ~cs_q[STAGES-1];
  assign sdi_s     = sd_q[STAGES-1];
endmodule

// File: rtl/sri_shift.sv
module sri_shift
  import sri_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cmd_rd,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam logic [CNT_W-1:0] CNT_FULL    = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST    = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_CMD     = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] CNT_CMDLAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_ADREND  = CNT_W'(ADDR_W + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W:0]   cmd_q, cmd_d;
  logic [DATA_W-2:0] dat_q, dat_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              sdo_q, sdo_d, oe_q, oe_d;
  logic              wstb_q, wstb_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  always_comb begin
    cnt_d   = cnt_q;
    cmd_d   = cmd_q;
    dat_d   = dat_q;
    tx_d    = tx_q;
    sdo_d   = sdo_q;
    oe_d    = oe_q;
    wstb_d  = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    if (!cs_act) begin
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      if (sclk_rise && cnt_q != CNT_FULL) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q < CNT_ADREND) begin
          cmd_d[cnt_q[2:0]] = sdi_s;
        end else if (cnt_q >= CNT_CMD && cnt_q < CNT_LAST) begin
          dat_d[cnt_q[2:0]] = sdi_s;
        end
        if (cnt_q == CNT_CMDLAST) begin
          tx_d = rd_byte;
        end
        if (cnt_q == CNT_LAST && !cmd_q[0]) begin
          wstb_d  = 1'b1;
          waddr_d = cmd_q[ADDR_W:1];
          wdata_d = {sdi_s, dat_q};
        end
      end
      if (sclk_fall && cmd_q[0] && cnt_q >= CNT_CMD && cnt_q != CNT_FULL) begin
        sdo_d = tx_q[cnt_q[2:0]];
        oe_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmd_q   <= '0;
      dat_q   <= '0;
      tx_q    <= '0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      wstb_q  <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      cmd_q   <= cmd_d;
      dat_q   <= dat_d;
      tx_q    <= tx_d;
      sdo_q   <= sdo_d;
      oe_q    <= oe_d;
      wstb_q  <= wstb_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign rd_addr = cmd_q[ADDR_W:1];
  assign cmd_rd  = cmd_q[0];
  assign bit_cnt = cnt_q;
  assign wr_stb  = wstb_q;
  assign wr_addr = waddr_q;
  assign wr_data = wdata_q;
  assign sdo     = sdo_q;
  assign sdo_oe  = oe_q;
endmodule

// File: rtl/sri_regs.sv
module sri_regs
  import sri_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE = 8'hA7,
  parameter logic [DATA_W-1:0] EXP_KEY  = 8'h01
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_stb,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [STAT_CNT*DATA_W-1:0]   stat_in,
  output logic [DATA_W-1:0]            rd_byte,
  output logic [PRIM_CNT*DATA_W-1:0]   cfg_prim,
  output logic [EXP_CNT*DATA_W-1:0]    cfg_exp,
  output logic                         exp_mode,
  output logic                         soft_clr
);
  logic [DATA_W-1:0] ptr_q;
  logic              clr_q, clr_d;
  logic              wr_ptr, wr_exp, wr_prim;
  logic [DATA_W-1:0] prim_w [PRIM_CNT];
  logic [DATA_W-1:0] exp_w  [EXP_CNT];

  assign exp_mode = (ptr_q == EXP_KEY);

  always_comb begin
    wr_ptr  = wr_stb && (wr_addr == ADR_PTR);
    wr_exp  = wr_stb && exp_mode && !wr_ptr && (wr_addr[ADDR_W-1:EXP_AW] == '0);
    wr_prim = wr_stb && !exp_mode && !wr_ptr;
    clr_d   = wr_prim && (wr_addr == ADR_RST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= clr_d;
      if (clr_q) begin
        ptr_q <= '0;
      end else if (wr_ptr) begin
        ptr_q <= wr_data;
      end
    end
  end

  for (genvar i = 0; i < PRIM_CNT; i++) begin : g_prim
    if (prim_is_rw(ADDR_W'(i))) begin : g_rw
      logic [DATA_W-1:0] r_q;
      logic              en;
      assign en = wr_prim && (wr_addr == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r_q <= '0;
        end else if (clr_q) begin
          r_q <= '0;
        end else if (en) begin
          r_q <= wr_data;
        end
      end
      assign prim_w[i] = r_q;
    end else begin : g_ro
      assign prim_w[i] = '0;
    end
    assign cfg_prim[i*DATA_W +: DATA_W] = prim_w[i];
  end

  for (genvar j = 0; j < EXP_CNT; j++) begin : g_exp
    logic [DATA_W-1:0] r_q;
    logic              en;
    assign en = wr_exp && (wr_addr[EXP_AW-1:0] == EXP_AW'(j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (clr_q) begin
        r_q <= '0;
      end else if (en) begin
        r_q <= wr_data;
      end
    end
    assign exp_w[j] = r_q;
    assign cfg_exp[j*DATA_W +: DATA_W] = r_q;
  end

  always_comb begin
    rd_byte = '0;
    if (rd_addr == ADR_PTR) begin
      rd_byte = ptr_q;
    end else if (exp_mode) begin
      if (rd_addr[ADDR_W-1:EXP_AW] == '0) rd_byte = exp_w[rd_addr[EXP_AW-1:0]];
    end else if (rd_addr == ADR_ID) begin
      rd_byte = ID_VALUE;
    end else if (rd_addr == ADR_ST0) begin
      rd_byte = stat_in[0*DATA_W +: DATA_W];
    end else if (rd_addr == ADR_ST1) begin
      rd_byte = stat_in[1*DATA_W +: DATA_W];
    end else if (rd_addr == ADR_ST2) begin
      rd_byte = stat_in[2*DATA_W +: DATA_W];
    end else if (rd_addr <= PRIM_TOP) begin
      rd_byte = prim_w[rd_addr];
    end
  end

  assign soft_clr = clr_q;
endmodule

// File: rtl/sri_top.sv
module sri_top
  import sri_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE    = 8'hA7,
  parameter logic [DATA_W-1:0] EXP_KEY     = 8'h01,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       cs_n,
  input  logic                       sdi,
  input  logic [STAT_CNT*DATA_W-1:0] stat_in,
  output logic                       sdo,
  output logic                       sdo_oe,
  output logic                       exp_mode,
  output logic [PRIM_CNT*DATA_W-1:0] cfg_prim,
  output logic [EXP_CNT*DATA_W-1:0]  cfg_exp
);
  logic [1:0]        rst_pipe;
  logic              rst_ns;
  logic              sclk_rise, sclk_fall, cs_act, sdi_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_byte, wr_data;
  logic              cmd_rd, wr_stb, soft_clr;
  logic [CNT_W-1:0]  bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  sri_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ns), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .sdi_s(sdi_s)
  );

  sri_shift u_shift (
    .clk(clk), .rst_n(rst_ns), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .sdi_s(sdi_s), .rd_byte(rd_byte), .rd_addr(rd_addr),
    .cmd_rd(cmd_rd), .bit_cnt(bit_cnt), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  sri_regs #(.ID_VALUE(ID_VALUE), .EXP_KEY(EXP_KEY)) u_regs (
    .clk(clk), .rst_n(rst_ns), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .stat_in(stat_in), .rd_byte(rd_byte),
    .cfg_prim(cfg_prim), .cfg_exp(cfg_exp), .exp_mode(exp_mode), .soft_clr(soft_clr)
  );
endmodule

// File: rtl/sri_chk.sv
module sri_chk
  import sri_pkg::*;
#(
  parameter int STAGES = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n,
  input logic                       sdo,
  input logic                       sdo_oe,
  input logic                       sclk_fall,
  input logic                       cmd_rd,
  input logic [CNT_W-1:0]           bit_cnt,
  input logic                       wr_stb,
  input logic                       soft_clr,
  input logic                       exp_mode,
  input logic [PRIM_CNT*DATA_W-1:0] cfg_prim,
  input logic [EXP_CNT*DATA_W-1:0]  cfg_exp
);
  localparam int IDLE_LIM = STAGES + 2;
  int unsigned idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    idle_cnt <= 0;
    else if (!cs_n)                idle_cnt <= 0;
    else if (idle_cnt < IDLE_LIM)  idle_cnt <= idle_cnt + 1;
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS));

  // R4
  full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (bit_cnt == CNT_W'(FRAME_BITS)));

  // R3
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && idle_cnt >= IDLE_LIM) |-> !sdo_oe);

  // R3
  write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> cmd_rd);

  // R2
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sclk_fall) |-> $stable(sdo));

  // R8
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (cfg_prim == '0 && cfg_exp == '0 && !exp_mode));
endmodule

bind sri_top sri_chk #(.STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_ns), .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe),
  .sclk_fall(sclk_fall), .cmd_rd(cmd_rd), .bit_cnt(bit_cnt), .wr_stb(wr_stb),
  .soft_clr(soft_clr), .exp_mode(exp_mode), .cfg_prim(cfg_prim), .cfg_exp(cfg_exp)
);

// File: tb/tb_sri_top.sv
module tb_sri_top;
  localparam int HALF = 8;
  localparam logic [7:0] ID_V = 8'hA7;
  localparam logic [7:0] KEY  = 8'h01;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, sdi;
  logic [23:0]  stat;
  logic sdo, sdo_oe, exp_mode;
  logic [175:0] cfg_prim;
  logic [127:0] cfg_exp;

  always #4 clk = ~clk;

  sri_top dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .stat_in(stat),
    .sdo(sdo), .sdo_oe(sdo_oe), .exp_mode(exp_mode), .cfg_prim(cfg_prim), .cfg_exp(cfg_exp)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] prim_m [32];
  logic [7:0] exp_m  [16];
  logic [7:0] ptr_m;

  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit m_rw(input logic [4:0] a);
    return (a <= 5'h15) && a != 5'h00 && a != 5'h04 && a != 5'h05 && a != 5'h0A && a != 5'h13;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 32; i++) prim_m[i] = 8'h00;
    for (int i = 0; i < 16; i++) exp_m[i] = 8'h00;
    ptr_m = 8'h00;
  endtask

  function automatic logic [7:0] m_read(input logic [4:0] a);
    if (a == 5'h1F) return ptr_m;
    if (ptr_m == KEY) return (a < 5'h10) ? exp_m[a[3:0]] : 8'h00;
    if (a == 5'h00) return ID_V;
    if (a == 5'h04) return stat[7:0];
    if (a == 5'h05) return stat[15:8];
    if (a == 5'h13) return stat[23:16];
    if (m_rw(a)) return prim_m[a];
    return 8'h00;
  endfunction

  task automatic m_write(input logic [4:0] a, input logic [7:0] d);
    if (a == 5'h1F) ptr_m = d;
    else if (ptr_m == KEY) begin
      if (a < 5'h10) exp_m[a[3:0]] = d;
    end else if (a == 5'h0A) m_clear();
    else if (m_rw(a)) prim_m[a] = d;
  endtask

  function automatic logic [175:0] m_prim_vec();
    logic [175:0] v;
    for (int i = 0; i < 22; i++) v[8*i +: 8] = prim_m[i];
    return v;
  endfunction

  function automatic logic [127:0] m_exp_vec();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = exp_m[i];
    return v;
  endfunction

  // Driver: one framed transfer; reads push the expected byte to the scoreboard.
  task automatic xfer(input bit rd, input logic [4:0] a, input logic [1:0] ign,
                      input logic [7:0] wd, input string tag);
    logic [15:0] fr;
    logic [7:0]  got;
    bit          oe_bad;
    fr = {wd, ign, a, rd};
    got = 8'h00;
    oe_bad = 1'b0;
    if (rd) begin
      exp_q.push_back(m_read(a));
      tag_q.push_back(tag);
    end
    cs_n = 1'b0;
    wait_clks(HALF);
    for (int i = 0; i < 16; i++) begin
      sdi = fr[i];
      wait_clks(HALF);
      if (i >= 8) begin
        if (rd) got[i-8] = sdo;
        if (sdo_oe !== rd) oe_bad = 1'b1;
      end
      sclk = 1'b1;
      wait_clks(HALF);
      sclk = 1'b0;
    end
    wait_clks(HALF);
    cs_n = 1'b1;
    wait_clks(HALF);
    if (rd) begin
      got_q.push_back(got);
      check(!oe_bad, "R2 sdo_oe high through read data phase", 256'(oe_bad), 256'(0));
    end else begin
      m_write(a, wd);
      check(!oe_bad, "R3 sdo_oe low during write frame", 256'(oe_bad), 256'(0));
    end
    check(sdo_oe == 1'b0, "R3 sdo_oe low with cs_n high", 256'(sdo_oe), 256'(0));
  endtask

  // Write frame cut short after nbits rising edges.
  task automatic xfer_short(input logic [4:0] a, input logic [7:0] wd, input int nbits);
    logic [15:0] fr;
    fr = {wd, 2'b00, a, 1'b0};
    cs_n = 1'b0;
    wait_clks(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = fr[i];
      wait_clks(HALF);
      sclk = 1'b1;
      wait_clks(HALF);
      sclk = 1'b0;
    end
    wait_clks(HALF);
    cs_n = 1'b1;
    wait_clks(2 * HALF);
  endtask

  // Monitor: compares observed read bytes against expected ones in order.
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() != 0 && exp_q.size() != 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g == e, {t, " (R1 R2 read frame)"}, 256'(g), 256'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check_cfg(input string req);
    check(cfg_prim == m_prim_vec(), {req, " cfg_prim"}, 256'(cfg_prim), 256'(m_prim_vec()));
    check(cfg_exp == m_exp_vec(), {req, " cfg_exp"}, 256'(cfg_exp), 256'(m_exp_vec()));
    check(exp_mode == (ptr_m == KEY), {req, " exp_mode"}, 256'(exp_mode), 256'(ptr_m == KEY));
  endtask

  initial begin
    m_clear();
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0; stat = 24'h3C815E;
    wait_clks(10);
    rst_n = 1'b1;
    wait_clks(6);

    // R12 reset state
    check(sdo_oe == 1'b0, "R12 sdo_oe after reset", 256'(sdo_oe), 256'(0));
    check_cfg("R12 reset");

    // R6 ID read, write ignored
    xfer(1'b1, 5'h00, 2'b00, 8'h00, "R6 id read");
    xfer(1'b0, 5'h00, 2'b00, 8'hFF, "R6 id write");
    xfer(1'b1, 5'h00, 2'b00, 8'h00, "R6 id after write");

    // R5 configuration registers, several patterns
    xfer(1'b0, 5'h01, 2'b00, 8'hA5, "");
    xfer(1'b0, 5'h03, 2'b00, 8'h5A, "");
    xfer(1'b0, 5'h0F, 2'b00, 8'hFF, "");
    xfer(1'b0, 5'h12, 2'b00, 8'h44, "");
    xfer(1'b0, 5'h15, 2'b00, 8'h01, "");
    xfer(1'b1, 5'h01, 2'b00, 8'h00, "R5 rd 01");
    xfer(1'b1, 5'h03, 2'b00, 8'h00, "R5 rd 03");
    xfer(1'b1, 5'h0F, 2'b00, 8'h00, "R5 rd 0F");
    xfer(1'b1, 5'h15, 2'b00, 8'h00, "R5 rd 15");
    check_cfg("R5 after writes");

    // R5 unmapped primary addresses
    xfer(1'b0, 5'h1A, 2'b00, 8'h77, "");
    xfer(1'b1, 5'h1A, 2'b00, 8'h00, "R5 unmapped 1A");
    xfer(1'b1, 5'h16, 2'b00, 8'h00, "R5 unmapped 16");

    // R7 status registers
    xfer(1'b1, 5'h04, 2'b00, 8'h00, "R7 status 04");
    xfer(1'b1, 5'h05, 2'b00, 8'h00, "R7 status 05");
    xfer(1'b1, 5'h13, 2'b00, 8'h00, "R7 status 13");
    xfer(1'b0, 5'h04, 2'b00, 8'hFF, "");
    stat = 24'h00C3_96;
    xfer(1'b1, 5'h04, 2'b00, 8'h00, "R7 status 04 new input, write ignored");
    check_cfg("R7 after status write");

    // R11 ignored command bits
    xfer(1'b0, 5'h07, 2'b11, 8'h3C, "");
    xfer(1'b1, 5'h07, 2'b00, 8'h00, "R11 rd 07 plain");
    xfer(1'b1, 5'h07, 2'b10, 8'h00, "R11 rd 07 with bit7 set");

    // R4 short transfers discarded
    xfer_short(5'h07, 8'h99, 10);
    xfer_short(5'h07, 8'h99, 15);
    xfer(1'b1, 5'h07, 2'b00, 8'h00, "R4 rd 07 after short frames");
    check_cfg("R4 after short frames");

    // R8 reset register reads zero
    xfer(1'b1, 5'h0A, 2'b00, 8'h00, "R8 rd 0A");

    // R9 non-key pointer keeps the primary bank
    xfer(1'b0, 5'h1F, 2'b00, 8'h02, "");
    check_cfg("R9 pointer 02");
    xfer(1'b1, 5'h01, 2'b00, 8'h00, "R9 primary 01 with pointer 02");
    xfer(1'b1, 5'h1F, 2'b00, 8'h00, "R9 rd pointer 02");

    // R9 key selects expanded bank
    xfer(1'b0, 5'h1F, 2'b00, KEY, "");
    check_cfg("R9 pointer key");
    xfer(1'b0, 5'h00, 2'b00, 8'h11, "");
    xfer(1'b0, 5'h01, 2'b00, 8'h22, "");
    xfer(1'b0, 5'h0A, 2'b00, 8'h77, "");
    xfer(1'b0, 5'h0F, 2'b00, 8'hF0, "");
    xfer(1'b1, 5'h00, 2'b00, 8'h00, "R9 exp 00");
    xfer(1'b1, 5'h0A, 2'b00, 8'h00, "R9 exp 0A");
    xfer(1'b1, 5'h0F, 2'b00, 8'h00, "R9 exp 0F");
    xfer(1'b1, 5'h1F, 2'b00, 8'h00, "R9 rd pointer key");
    check_cfg("R9 expanded writes");

    // R10 out-of-range in expanded mode
    xfer(1'b0, 5'h12, 2'b00, 8'hEE, "");
    xfer(1'b1, 5'h12, 2'b00, 8'h00, "R10 exp rd 12");
    check_cfg("R10 exp write 12 ignored");

    // R9 back to primary: contents kept
    xfer(1'b0, 5'h1F, 2'b00, 8'h00, "");
    xfer(1'b1, 5'h01, 2'b00, 8'h00, "R9 primary 01 kept");
    xfer(1'b1, 5'h12, 2'b00, 8'h00, "R10 primary 12 untouched");
    check_cfg("R9 back to primary");

    // R8 soft reset
    xfer(1'b0, 5'h1F, 2'b00, KEY, "");
    xfer(1'b0, 5'h1F, 2'b00, 8'h00, "");
    xfer(1'b0, 5'h0A, 2'b00, 8'h5A, "");
    check_cfg("R8 after reset register write");
    xfer(1'b1, 5'h01, 2'b00, 8'h00, "R8 rd 01 after soft reset");
    xfer(1'b0, 5'h1F, 2'b00, KEY, "");
    xfer(1'b1, 5'h0F, 2'b00, 8'h00, "R8 exp 0F after soft reset");
    xfer(1'b0, 5'h1F, 2'b00, 8'h00, "");

    wait_clks(4 * HALF);
    check(exp_q.size() == 0, "R1 all reads observed", 256'(exp_q.size()), 256'(0));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule